// File: doc/BRIEF.md
# Iterative Chebyshev Arctangent Evaluator

This block returns the arctangent, in radians, of a signed fixed-point argument. It evaluates a six-term Chebyshev series with a backward recurrence. The recurrence starts from two zero terms and moves from the highest coefficient down to the lowest. Each step reuses one rounding multiplier, so one recurrence step completes per clock. The coefficients are constants placed at the Chebyshev nodes. arctan is odd, so the even-order coefficients are zero.

The series is valid only for arguments between −1 and +1. The caller supplies the argument together with its reciprocal, which is computed elsewhere. When the argument magnitude exceeds one, the block evaluates the series on the reciprocal. It then folds the result back with the identity arctan(x) = ±π/2 − arctan(1/x), taking the sign of x. A single start pulse launches an operation. The busy flag covers the run, and a one-cycle done pulse marks a result that stays in place until the next accepted start.

Top module: `cheb_atan`

## Requirements
- R1: While reset is asserted and right after it, busy and done are low and result is zero.
- R2: For an argument x_in (signed, 15 fractional bits) with magnitude at most 1.0, result (signed, 14 fractional bits, radians) is within 70 LSB of arctan(x_in/32768)·16384.
- R3: For x_in above +1.0 (greater than 32768), the series runs on recip_in (signed, 15 fractional bits, the reciprocal of the argument). The result is π/2 minus that value, within 70 LSB of the true arctangent.
- R4: For x_in below −1.0 (less than −32768), the result is −π/2 minus the series value on recip_in, within 70 LSB of the true arctangent.
- R5: An argument of exactly zero gives a result of exactly zero.
- R6: After the clock edge that accepts start, busy is high for exactly seven cycles (coefficient count plus one). done is high for the single cycle after busy falls, and the result is valid in that cycle.
- R7: After done, result keeps its value until another start is accepted, whatever x_in and recip_in do.
- R8: A start pulse while busy is ignored. The run in progress keeps its length and result, and no second run follows.
- R9: recip_in has no effect when the argument magnitude is at most 1.0.
- R10: Arguments of exactly +1.0 and −1.0 use the direct path and give ±π/4 within 70 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches an operation when the block is idle |
| x_in | input | 17 | Argument, signed, 15 fractional bits |
| recip_in | input | 17 | Reciprocal of the argument, signed, 15 fractional bits |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse when result is updated |
| result | output | 17 | Arctangent in radians, signed, 14 fractional bits |

## Verification
The edge that samples start is edge 0. Busy rises after edge 0. Busy falls and done rises after edge 7, with the new result present in the same cycle as done. The driver task samples at falling edges. It counts busy-high samples from the first falling edge after the accepting edge, then checks done and the missing restart at the next falling edges. The monitor pops one expected value for each done it sees at a falling edge. Because every operation is due a fixed seven cycles after its start, results arrive in issue order and the queue compares each against a real-valued arctangent with a fixed tolerance.

// File: rtl/cheb_atan_pkg.sv
package cheb_atan_pkg;

    localparam int ARG_FRAC = 15;
    localparam int RES_FRAC = 14;
    localparam int NCOEF    = 6;
    // pi/2 with RES_FRAC fractional bits
    localparam int PI2_Q    = 25736;

    typedef enum logic [1:0] {
        RG_MID = 2'd0,
        RG_POS = 2'd1,
        RG_NEG = 2'd2
    } region_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_ITER  = 2'd2,
        PH_FINAL = 2'd3
    } phase_e;

    // Node-fitted coefficients (ARG_FRAC fractional bits); even orders vanish
    function automatic int cheb_coef(input int n);
        case (n)
            1:       return 27147;
            3:       return -1555;
            5:       return 180;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/cheb_atan_coef.sv
module cheb_atan_coef
    import cheb_atan_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int NC    = 6,
    localparam int IW   = $clog2(NC)
) (
    input  logic [IW-1:0]           idx,
    output logic signed [ACC_W-1:0] coef
);

    logic signed [ACC_W-1:0] tbl [NC];

    generate
        for (genvar g = 0; g < NC; g++) begin : g_tbl
            assign tbl[g] = ACC_W'(cheb_coef(g));
        end
    endgenerate

    always_comb begin
        coef = '0;
        if (int'(idx) < NC) coef = tbl[idx];
    end

endmodule

// File: rtl/cheb_atan_mul.sv
module cheb_atan_mul #(
    parameter int A_W  = 17,
    parameter int B_W  = 20,
    parameter int FRAC = 15,
    localparam int P_W = A_W + B_W
) (
    input  logic signed [A_W-1:0] a,
    input  logic signed [B_W-1:0] b,
    input  logic                  dbl,
    output logic signed [B_W-1:0] p
);

    localparam logic signed [P_W-1:0] HALF_ONE = P_W'(1) <<< (FRAC - 1);
    localparam logic signed [P_W-1:0] HALF_DBL = P_W'(1) <<< (FRAC - 2);

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] rnd_one;
    logic signed [P_W-1:0] rnd_dbl;

    always_comb begin
        prod    = P_W'(a) * P_W'(b);
        rnd_one = (prod + HALF_ONE) >>> FRAC;
        rnd_dbl = (prod + HALF_DBL) >>> (FRAC - 1);
        p       = dbl ? B_W'(rnd_dbl) : B_W'(rnd_one);
    end

endmodule

// File: rtl/cheb_atan_rr.sv
module cheb_atan_rr
    import cheb_atan_pkg::*;
#(
    parameter int A_W  = 17,
    parameter int FRAC = 15
) (
    input  logic signed [A_W-1:0] x_raw,
    input  logic signed [A_W-1:0] recip,
    output logic signed [A_W-1:0] arg,
    output region_e               region
);

    localparam logic signed [A_W-1:0] ONE = A_W'(1) <<< FRAC;

    always_comb begin
        if (x_raw > ONE) begin
            region = RG_POS;
            arg    = recip;
        end else if (x_raw < -ONE) begin
            region = RG_NEG;
            arg    = recip;
        end else begin
            region = RG_MID;
            arg    = x_raw;
        end
    end

endmodule

// File: rtl/cheb_atan_fix.sv
module cheb_atan_fix
    import cheb_atan_pkg::*;
#(
    parameter int ACC_W = 20,
    parameter int R_W   = 17,
    localparam int SH   = ARG_FRAC - RES_FRAC
) (
    input  logic signed [ACC_W-1:0] f_acc,
    input  region_e                 region,
    output logic signed [R_W-1:0]   res
);

    localparam logic signed [R_W-1:0]   PI_HALF = R_W'(PI2_Q);
    localparam logic signed [ACC_W-1:0] RND     = ACC_W'(1) <<< (SH - 1);

    logic signed [ACC_W-1:0] f_shr;
    logic signed [R_W-1:0]   f_res;

    always_comb begin
        f_shr = (f_acc + RND) >>> SH;
        f_res = R_W'(f_shr);
        case (region)
            RG_POS:  res = PI_HALF - f_res;
            RG_NEG:  res = -PI_HALF - f_res;
            default: res = f_res;
        endcase
    end

endmodule

// File: rtl/cheb_atan.sv
module cheb_atan
    import cheb_atan_pkg::*;
#(
    parameter int ARG_W = 17,
    parameter int RES_W = 17,
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ARG_W-1:0] x_in,
    input  logic [ARG_W-1:0] recip_in,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);

    localparam int IW    = $clog2(NCOEF);
    localparam int RUN_W = $clog2(NCOEF + 2);
    localparam logic [IW-1:0] TOP_IDX = IW'(NCOEF - 1);

    typedef struct packed {
        phase_e                  phase;
        logic [IW-1:0]           idx;
        logic signed [ARG_W-1:0] xraw;
        logic signed [ARG_W-1:0] rcp;
        logic signed [ARG_W-1:0] arg;
        region_e                 region;
        logic signed [ACC_W-1:0] d1;
        logic signed [ACC_W-1:0] d2;
        logic signed [RES_W-1:0] res;
        logic                    done;
    } state_t;

    state_t st_q, st_d;

    logic signed [ARG_W-1:0] rr_arg;
    region_e                 rr_region;
    logic signed [ACC_W-1:0] mul_p;
    logic signed [ACC_W-1:0] coef;
    logic signed [ACC_W-1:0] d_new;
    logic signed [ACC_W-1:0] f_acc;
    logic signed [RES_W-1:0] fix_res;
    logic                    mul_dbl;

    cheb_atan_rr #(.A_W(ARG_W), .FRAC(ARG_FRAC)) u_rr (
        .x_raw  (st_q.xraw),
        .recip  (st_q.rcp),
        .arg    (rr_arg),
        .region (rr_region)
    );

    assign mul_dbl = (st_q.phase == PH_ITER);

    cheb_atan_mul #(.A_W(ARG_W), .B_W(ACC_W), .FRAC(ARG_FRAC)) u_mul (
        .a   (st_q.arg),
        .b   (st_q.d1),
        .dbl (mul_dbl),
        .p   (mul_p)
    );

    cheb_atan_coef #(.ACC_W(ACC_W), .NC(NCOEF)) u_coef (
        .idx  (st_q.idx),
        .coef (coef)
    );

    // recurrence step and closing step share the multiplier output
    always_comb begin
        d_new = mul_p - st_q.d2 + coef;
        f_acc = mul_p - st_q.d2 + (coef >>> 1);
    end

    cheb_atan_fix #(.ACC_W(ACC_W), .R_W(RES_W)) u_fix (
        .f_acc  (f_acc),
        .region (st_q.region),
        .res    (fix_res)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.xraw  = $signed(x_in);
                    st_d.rcp   = $signed(recip_in);
                    st_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                st_d.arg    = rr_arg;
                st_d.region = rr_region;
                st_d.d1     = '0;
                st_d.d2     = '0;
                st_d.idx    = TOP_IDX;
                st_d.phase  = PH_ITER;
            end
            PH_ITER: begin
                st_d.d2  = st_q.d1;
                st_d.d1  = d_new;
                st_d.idx = st_q.idx - IW'(1);
                if (st_q.idx == IW'(1)) st_d.phase = PH_FINAL;
            end
            default: begin
                st_d.res   = fix_res;
                st_d.done  = 1'b1;
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = (st_q.phase != PH_IDLE);
    assign done   = st_q.done;
    assign result = st_q.res;

    // busy-run length counter for the checks below
    logic [RUN_W-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_q <= '0;
        else if (busy) run_q <= run_q + RUN_W'(1);
        else           run_q <= '0;
    end

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RUN_W'(NCOEF + 1));

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> $stable(result));

    // R3 R4
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($signed(result) <= RES_W'(PI2_Q) && $signed(result) >= -RES_W'(PI2_Q)));

endmodule

// File: tb/cheb_atan_bench.sv
`timescale 1ns/1ps
module cheb_atan_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] x_in = '0;
    logic [16:0] recip_in = '0;
    logic        busy;
    logic        done;
    logic [16:0] result;

    localparam int TOL = 70;

    always #2 clk = ~clk;

    cheb_atan u_cheb_atan (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .x_in     (x_in),
        .recip_in (recip_in),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    typedef struct {
        int    x;
        int    exp_v;
        int    tol;
        string req;
    } exp_t;

    exp_t sbq[$];
    int checks = 0;
    int failures = 0;

    task automatic check(input bit ok, input string req, input int act,
                         input int expv, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    function automatic int ref_q(input int x);
        real v;
        v = $atan(real'(x) / 32768.0) * 16384.0;
        return int'(v);
    endfunction

    function automatic int recip_q(input int x);
        return int'(1073741824.0 / real'(x));
    endfunction

    // driver: push expectation, launch, check busy/done timing (R6, R8)
    task automatic run_op(input int x, input int rcp, input string req,
                          input int tol, input bit poke);
        exp_t e;
        int n;
        e.x = x; e.exp_v = ref_q(x); e.tol = tol; e.req = req;
        @(negedge clk);
        while (busy) @(negedge clk);
        sbq.push_back(e);
        x_in = 17'(x);
        recip_in = 17'(rcp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (busy && n < 20) begin
            n++;
            if (poke && n == 3) begin
                start = 1'b1;
                x_in = 17'(12345);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(n == 7, "R6", n, 7, "busy cycles");
        check(done == 1'b1, "R6", int'(done), 1, "done after busy");
        if (poke) begin
            @(negedge clk);
            check(busy == 1'b0 && done == 1'b0, "R8", int'(busy), 0, "no restart");
        end
    endtask

    // monitor: one expectation per done pulse
    exp_t mon_e;
    int   mon_d;
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R6", 1, 0, "unexpected done");
            end else begin
                mon_e = sbq.pop_front();
                mon_d = $signed(result) - mon_e.exp_v;
                if (mon_d < 0) mon_d = -mon_d;
                check(mon_d <= mon_e.tol, mon_e.req, $signed(result), mon_e.exp_v, "result");
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int held;
        repeat (3) @(negedge clk);
        // R1
        check(busy == 1'b0, "R1", int'(busy), 0, "busy in reset");
        check(done == 1'b0, "R1", int'(done), 0, "done in reset");
        check(result == '0, "R1", int'(result), 0, "result in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && result == '0, "R1", int'(result), 0, "after reset");

        // R2 direct path
        run_op(16384, 0, "R2", TOL, 1'b0);
        run_op(-16384, 0, "R2", TOL, 1'b0);
        run_op(8000, 0, "R2", TOL, 1'b0);
        run_op(-30000, 0, "R2", TOL, 1'b0);
        run_op(3277, 0, "R2", TOL, 1'b0);
        // R10 boundaries
        run_op(32768, 0, "R10", TOL, 1'b0);
        run_op(-32768, 0, "R10", TOL, 1'b0);
        // R3 above one
        run_op(65535, recip_q(65535), "R3", TOL, 1'b0);
        run_op(40000, recip_q(40000), "R3", TOL, 1'b0);
        run_op(32769, recip_q(32769), "R3", TOL, 1'b0);
        // R4 below minus one
        run_op(-65536, recip_q(-65536), "R4", TOL, 1'b0);
        run_op(-45000, recip_q(-45000), "R4", TOL, 1'b0);
        // R5 exact zero
        run_op(0, 0, "R5", 0, 1'b0);
        // R9 reciprocal ignored in range
        run_op(10000, 12345, "R9", TOL, 1'b0);
        run_op(-20000, -777, "R9", TOL, 1'b0);
        // R8 start while busy
        run_op(24000, 0, "R8", TOL, 1'b1);

        // R7 hold after done
        @(negedge clk);
        held = int'(result);
        x_in = 17'(50000);
        recip_in = 17'(999);
        repeat (6) @(negedge clk);
        check(int'(result) == held, "R7", int'(result), held, "held result");
        check(done == 1'b0, "R7", int'(done), 0, "no spurious done");

        // sweep across the whole input range
        for (int x = -65536; x <= 65535; x += 4111) begin
            if (x > 32768)       run_op(x, recip_q(x), "R3", TOL, 1'b0);
            else if (x < -32768) run_op(x, recip_q(x), "R4", TOL, 1'b0);
            else                 run_op(x, 0, "R2", TOL, 1'b0);
        end

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R6", sbq.size(), 0, "pending results");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule